// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of interrupting devices and a processor. Each device drives its own request line, and every line carries a fixed priority. One additional non-maskable input sits above all of them. The controller picks the most urgent pending request and compares it with the priority now in service. If the request ranks higher, it asks the processor for service. Once the processor acknowledges, the controller collects a vector from the device and issues a handler index into a vector table.

The controller keeps a stack of in-service priorities. A handler entry pushes its level onto the stack, and an end-of-service strobe pops it, so a more urgent source can nest inside a less urgent one. A device that is granted but never returns a vector is caught by a cycle-count timeout, which raises a bus-error pulse in place of a handler call. The non-maskable input is edge-sensitive. A fresh edge that arrives while the non-maskable handler is running is remembered and served after that handler ends.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, cpu_req, grant_valid, call_valid and bus_err are low and cur_prio is 0 (nothing in service).
- R2: Line bit i carries priority level i+1, and the non-maskable source carries level N_LINES+1. Among simultaneous requests the highest level is granted and shows on grant_level.
- R3: A pending request whose level is not above cur_prio does not raise cpu_req until end-of-service strobes lower cur_prio below it.
- R4: A request above the level in service is accepted while that service is running (nesting), and cur_prio then rises to the new level.
- R5: cpu_req rises on the cycle after an eligible request appears and stays high until cpu_ack. On the cycle after cpu_ack, cpu_req is low and grant_valid is high with the granted level.
- R6: A vector presented with vec_valid while grant_valid is high produces, one cycle later, a single-cycle call_valid with call_index equal to that vector, and cur_prio equals the granted level. A vector on the last cycle of the timeout window is still accepted.
- R7: If no vector arrives within TIMEOUT_CYCLES cycles of the grant, bus_err pulses for one cycle, grant_valid drops, no call is issued and cur_prio is unchanged.
- R8: An eoi strobe returns cur_prio to the level that was in service before the most recent entry. An eoi with nothing in service has no effect.
- R9: A rising edge on nmi is latched and served even when a line-driven level is in service. Holding nmi high after its service starts raises no further request.
- R10: A new nmi rising edge during non-maskable service does not raise cpu_req until that service ends with eoi. It is then served.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | N_LINES | Level requests, bit i has priority i+1 |
| nmi | input | 1 | Non-maskable request, rising-edge sensitive |
| cpu_ack | input | 1 | Processor acknowledge of cpu_req |
| vec_valid | input | 1 | Device presents its vector |
| vec_in | input | VEC_W | Vector from the granted device |
| eoi | input | 1 | End-of-service strobe, pops the in-service stack |
| cpu_req | output | 1 | Interrupt request to the processor |
| grant_valid | output | 1 | Waiting for the granted device's vector |
| grant_level | output | $clog2(N_LINES+2) | Level being granted |
| call_valid | output | 1 | One-cycle handler call pulse |
| call_index | output | VEC_W | Vector table entry to call |
| bus_err | output | 1 | One-cycle pulse when the vector timeout expires |
| cur_prio | output | $clog2(N_LINES+2) | Level currently in service, 0 when idle |

## Verification
The bench builds the controller with four request lines and a five-cycle vector timeout. At that size the full nesting depth fits in a short test: line levels 1 to 4 plus the non-maskable level 5. The short timeout makes both edges of the window cheap to reach, namely a vector on the last allowed cycle and expiry one cycle later. Each scenario starts from reset. Cycle timing is checked at the ports: the extra cycle the edge latch adds before a non-maskable request appears, and the one-cycle lag between an eoi and a newly eligible request.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;

    typedef enum logic [1:0] {
        HS_IDLE  = 2'd0,
        HS_ASK   = 2'd1,
        HS_FETCH = 2'd2
    } hs_state_e;

    typedef struct packed {
        logic call;
        logic err;
    } fetch_result_t;

endpackage

// File: rtl/irq_resolver.sv
module irq_resolver #(
    parameter int N_LINES = 7,
    parameter int PW      = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] irq_lines,
    input  logic               nmi,
    input  logic               nmi_taken,
    output logic [PW-1:0]      best_prio
);
    localparam logic [PW-1:0] NMI_LVL = PW'(N_LINES + 1);

    logic nmi_q;
    logic nmi_pend;
    logic nmi_rise;

    assign nmi_rise = nmi && !nmi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_q    <= 1'b0;
            nmi_pend <= 1'b0;
        end else begin
            nmi_q    <= nmi;
            nmi_pend <= nmi_rise || (nmi_pend && !nmi_taken);
        end
    end

    always_comb begin
        best_prio = '0;
        for (int i = 0; i < N_LINES; i++) begin
            if (irq_lines[i]) best_prio = PW'(i + 1);
        end
        if (nmi_pend) best_prio = NMI_LVL;
    end

    a_r9_edge_latched: assert property (@(posedge clk) disable iff (rst)
        (nmi && !nmi_q) |=> (best_prio == NMI_LVL));

endmodule

// File: rtl/irq_prio_stack.sv
module irq_prio_stack #(
    parameter int PW    = 4,
    parameter int DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [PW-1:0] push_lvl,
    input  logic          pop,
    output logic [PW-1:0] top_lvl
);
    localparam int SPW  = $clog2(DEPTH + 1);
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [PW-1:0]  mem [DEPTH];
    logic [SPW-1:0] sp;
    logic [SPW-1:0] sp_m1;
    logic           do_pop;

    assign sp_m1  = sp - SPW'(1);
    assign do_pop = pop && (sp != '0);
    assign top_lvl = (sp == '0) ? '0 : mem[sp_m1[IDXW-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            case ({push, do_pop})
                2'b10: begin
                    mem[sp[IDXW-1:0]] <= push_lvl;
                    sp <= sp + SPW'(1);
                end
                2'b01: sp <= sp_m1;
                2'b11: mem[sp_m1[IDXW-1:0]] <= push_lvl;
                default: ;
            endcase
        end
    end

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (push && !do_pop) |-> (sp < SPW'(DEPTH)));

    a_r4_push_raises: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |=> (top_lvl > $past(top_lvl)));

    a_r8_empty_pop_idle: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && (sp == '0)) |=> (top_lvl == '0));

endmodule

// File: rtl/irq_handshake.sv
module irq_handshake
    import prio_irq_pkg::*;
#(
    parameter int PW             = 4,
    parameter int VW             = 8,
    parameter int TIMEOUT_CYCLES = 16,
    parameter int NMI_LEVEL      = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] best_prio,
    input  logic [PW-1:0] cur_prio,
    input  logic          cpu_ack,
    input  logic          vec_valid,
    input  logic [VW-1:0] vec_in,
    output logic          cpu_req,
    output logic          grant_valid,
    output logic [PW-1:0] grant_level,
    output logic          call_valid,
    output logic [VW-1:0] call_index,
    output logic          bus_err,
    output logic          push,
    output logic          nmi_taken
);
    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [TW-1:0] LAST = TW'(TIMEOUT_CYCLES - 1);

    hs_state_e     st;
    logic [PW-1:0] lvl_q;
    logic [TW-1:0] cnt;
    logic [VW-1:0] idx_q;
    fetch_result_t res_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= HS_IDLE;
            lvl_q <= '0;
            cnt   <= '0;
            idx_q <= '0;
            res_q <= '0;
        end else begin
            res_q <= '0;
            case (st)
                HS_IDLE: if (best_prio > cur_prio) begin
                    st    <= HS_ASK;
                    lvl_q <= best_prio;
                end
                HS_ASK: if (cpu_ack) begin
                    st  <= HS_FETCH;
                    cnt <= '0;
                end
                HS_FETCH: begin
                    if (vec_valid) begin
                        res_q.call <= 1'b1;
                        idx_q      <= vec_in;
                        st         <= HS_IDLE;
                    end else if (cnt == LAST) begin
                        res_q.err <= 1'b1;
                        st        <= HS_IDLE;
                    end else begin
                        cnt <= cnt + TW'(1);
                    end
                end
                default: st <= HS_IDLE;
            endcase
        end
    end

    assign cpu_req     = (st == HS_ASK);
    assign grant_valid = (st == HS_FETCH);
    assign grant_level = lvl_q;
    assign call_valid  = res_q.call;
    assign call_index  = idx_q;
    assign bus_err     = res_q.err;
    assign push        = (st == HS_FETCH) && vec_valid;
    assign nmi_taken   = (st == HS_ASK) && cpu_ack && (lvl_q == PW'(NMI_LEVEL));

    a_r5_req_held: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && !cpu_ack) |=> cpu_req);

    a_r3_start_above: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_req) |-> (grant_level > cur_prio));

    a_r6_call_single: assert property (@(posedge clk) disable iff (rst)
        call_valid |=> !call_valid);

    a_r7_err_after_grant: assert property (@(posedge clk) disable iff (rst)
        bus_err |-> ($past(grant_valid) && !call_valid && !grant_valid));

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
    parameter int N_LINES        = 7,
    parameter int VEC_W          = 8,
    parameter int TIMEOUT_CYCLES = 16,
    localparam int PW            = $clog2(N_LINES + 2)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_LINES-1:0] irq_lines,
    input  logic               nmi,
    input  logic               cpu_ack,
    input  logic               vec_valid,
    input  logic [VEC_W-1:0]   vec_in,
    input  logic               eoi,
    output logic               cpu_req,
    output logic               grant_valid,
    output logic [PW-1:0]      grant_level,
    output logic               call_valid,
    output logic [VEC_W-1:0]   call_index,
    output logic               bus_err,
    output logic [PW-1:0]      cur_prio
);
    localparam int DEPTH = N_LINES + 1;

    logic [PW-1:0] best_prio;
    logic          push;
    logic          nmi_taken;

    irq_resolver #(.N_LINES(N_LINES), .PW(PW)) u_resolver (
        .clk       (clk),
        .rst       (rst),
        .irq_lines (irq_lines),
        .nmi       (nmi),
        .nmi_taken (nmi_taken),
        .best_prio (best_prio)
    );

    irq_handshake #(
        .PW(PW), .VW(VEC_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES), .NMI_LEVEL(N_LINES + 1)
    ) u_handshake (
        .clk         (clk),
        .rst         (rst),
        .best_prio   (best_prio),
        .cur_prio    (cur_prio),
        .cpu_ack     (cpu_ack),
        .vec_valid   (vec_valid),
        .vec_in      (vec_in),
        .cpu_req     (cpu_req),
        .grant_valid (grant_valid),
        .grant_level (grant_level),
        .call_valid  (call_valid),
        .call_index  (call_index),
        .bus_err     (bus_err),
        .push        (push),
        .nmi_taken   (nmi_taken)
    );

    irq_prio_stack #(.PW(PW), .DEPTH(DEPTH)) u_stack (
        .clk      (clk),
        .rst      (rst),
        .push     (push),
        .push_lvl (grant_level),
        .pop      (eoi),
        .top_lvl  (cur_prio)
    );

endmodule

// File: tb/prio_irq_ctrl_tb_top.sv
module prio_irq_ctrl_tb_top;
    localparam int NL  = 4;
    localparam int VW  = 8;
    localparam int TMO = 5;
    localparam int PW  = $clog2(NL + 2);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NL-1:0] irq_lines = '0;
    logic          nmi = 1'b0;
    logic          cpu_ack = 1'b0;
    logic          vec_valid = 1'b0;
    logic [VW-1:0] vec_in = '0;
    logic          eoi = 1'b0;
    logic          cpu_req, grant_valid, call_valid, bus_err;
    logic [PW-1:0] grant_level, cur_prio;
    logic [VW-1:0] call_index;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    prio_irq_ctrl #(.N_LINES(NL), .VEC_W(VW), .TIMEOUT_CYCLES(TMO)) dut_i (
        .clk(clk), .rst(rst), .irq_lines(irq_lines), .nmi(nmi), .cpu_ack(cpu_ack),
        .vec_valid(vec_valid), .vec_in(vec_in), .eoi(eoi), .cpu_req(cpu_req),
        .grant_valid(grant_valid), .grant_level(grant_level), .call_valid(call_valid),
        .call_index(call_index), .bus_err(bus_err), .cur_prio(cur_prio)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        irq_lines = '0; nmi = 1'b0; cpu_ack = 1'b0; vec_valid = 1'b0; eoi = 1'b0;
        rst = 1'b1;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic accept(input int lvl, input int vec, input string tag);
        cpu_ack = 1'b1; step(); cpu_ack = 1'b0;
        chk({tag, " R5 grant_valid"}, int'(grant_valid), 1);
        chk({tag, " R5 req dropped"}, int'(cpu_req), 0);
        chk({tag, " R2 grant_level"}, int'(grant_level), lvl);
        vec_valid = 1'b1; vec_in = VW'(vec); step(); vec_valid = 1'b0;
        chk({tag, " R6 call_valid"}, int'(call_valid), 1);
        chk({tag, " R6 call_index"}, int'(call_index), vec);
        chk({tag, " R4 cur_prio"}, int'(cur_prio), lvl);
        step();
        chk({tag, " R6 call pulse ends"}, int'(call_valid), 0);
    endtask

    task automatic pop_once();
        eoi = 1'b1; step(); eoi = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(); step();
        chk("R1 cpu_req", int'(cpu_req), 0);
        chk("R1 grant_valid", int'(grant_valid), 0);
        chk("R1 call_valid", int'(call_valid), 0);
        chk("R1 bus_err", int'(bus_err), 0);
        chk("R1 cur_prio", int'(cur_prio), 0);
    endtask

    task automatic t_simultaneous();
        do_reset();
        irq_lines = 4'b0101; step();
        chk("R5 req rises", int'(cpu_req), 1);
        step();
        chk("R5 req held without ack", int'(cpu_req), 1);
        chk("R5 no grant before ack", int'(grant_valid), 0);
        accept(3, 8'h2A, "simul");
        chk("R3 lower line masked", int'(cpu_req), 0);
        step();
        chk("R3 equal level masked", int'(cpu_req), 0);
        pop_once();
        chk("R8 eoi to idle", int'(cur_prio), 0);
        chk("R3 no req same cycle as eoi", int'(cpu_req), 0);
        step();
        chk("R3 req after eoi", int'(cpu_req), 1);
    endtask

    task automatic t_nesting();
        do_reset();
        irq_lines = 4'b0001; step();
        accept(1, 8'h11, "nest1");
        irq_lines = 4'b1001; step();
        chk("R4 higher request nests", int'(cpu_req), 1);
        accept(4, 8'h44, "nest4");
        irq_lines = 4'b0000;
        pop_once();
        chk("R8 back to level 1", int'(cur_prio), 1);
        pop_once();
        chk("R8 back to idle", int'(cur_prio), 0);
        pop_once();
        chk("R8 empty eoi ignored", int'(cur_prio), 0);
        chk("R8 empty eoi no req", int'(cpu_req), 0);
        irq_lines = 4'b0010; step();
        chk("R8 service after empty eoi", int'(cpu_req), 1);
        accept(2, 8'h22, "after_empty");
    endtask

    task automatic t_timeout();
        do_reset();
        irq_lines = 4'b0100; step();
        cpu_ack = 1'b1; step(); cpu_ack = 1'b0;
        for (int k = 1; k < TMO; k++) begin
            step();
            chk("R7 grant still open", int'(grant_valid), 1);
            chk("R7 no early error", int'(bus_err), 0);
        end
        step();
        chk("R7 bus_err", int'(bus_err), 1);
        chk("R7 grant closed", int'(grant_valid), 0);
        chk("R7 no call", int'(call_valid), 0);
        chk("R7 cur_prio unchanged", int'(cur_prio), 0);
        irq_lines = '0; step();
        chk("R7 bus_err pulse", int'(bus_err), 0);
        do_reset();
        irq_lines = 4'b0100; step();
        cpu_ack = 1'b1; step(); cpu_ack = 1'b0;
        for (int k = 1; k < TMO; k++) step();
        vec_valid = 1'b1; vec_in = 8'h5C; step(); vec_valid = 1'b0;
        chk("R6 last-cycle vector call", int'(call_valid), 1);
        chk("R6 last-cycle vector index", int'(call_index), 8'h5C);
        chk("R6 last-cycle no error", int'(bus_err), 0);
    endtask

    task automatic t_nmi();
        do_reset();
        irq_lines = 4'b1000; step();
        accept(4, 8'h40, "line4");
        nmi = 1'b1; step();
        chk("R9 edge latch delay", int'(cpu_req), 0);
        step();
        chk("R9 nmi over level 4", int'(cpu_req), 1);
        accept(5, 8'hF0, "nmi1");
        step(); step();
        chk("R9 held nmi no retrigger", int'(cpu_req), 0);
        nmi = 1'b0; step();
        nmi = 1'b1; step(); step(); step();
        chk("R10 second edge masked", int'(cpu_req), 0);
        pop_once();
        chk("R10 eoi back to 4", int'(cur_prio), 4);
        chk("R10 no req on eoi cycle", int'(cpu_req), 0);
        step();
        chk("R10 pending nmi served", int'(cpu_req), 1);
        accept(5, 8'hF1, "nmi2");
        pop_once();
        step(); step();
        chk("R9 held nmi after service", int'(cpu_req), 0);
        chk("R9 level 4 in service", int'(cur_prio), 4);
    endtask

    initial begin
        t_reset();
        t_simultaneous();
        t_nesting();
        t_timeout();
        t_nmi();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule